// File: doc/BRIEF.md
# Indirect Register Write Port

This block lets a processor program many video control registers through one shared data port instead of addressing each one directly. A small pointer register, loaded through its own strobe, holds a 6-bit target register number and a flag that stops the number from advancing. Every byte written to the indirect port is passed on as a single-cycle write strobe, with the register number and the data, to a control register file that sits downstream.

While the flag is clear, the pointer moves to the next register number after each indirect write. A host can therefore fill a run of consecutive registers with a burst of writes. While the flag is set, every write goes to the same register. Only certain register numbers are implemented. The block drops writes to any other number, and it also drops writes to the pointer register's own number. In both cases the pointer still behaves as if the write had been accepted. Three extra register numbers become writable only while an extended-feature input is high.

Top module: `ireg_port`

## Requirements
- R1: After reset, `reg_we` is 0 and the pointer holds number 0 with auto-increment enabled, so the first indirect write targets register 0.
- R2: A port write (`port_wr_en`=1) to a writable number makes `reg_we` 1 on the next cycle, with `reg_num` equal to the pointer number and `reg_data` equal to the written byte. Without a port write, `reg_we` stays 0.
- R3: A direct pointer load (`ptr_wr_en`=1) takes bit 7 of `ptr_wr_data` as the inhibit flag and bits 5..0 as the register number. Bit 6 is ignored.
- R4: While the inhibit flag is 0, the pointer number goes up by one after every port write.
- R5: While the inhibit flag is 1, repeated port writes all target the same register number.
- R6: Register numbers 0 to 23 and 32 to 46 are writable. Port writes to numbers 24, 28 to 31 and 47 to 63 produce no strobe.
- R7: Numbers 25 to 27 are writable only when `ext_en` is 1 in the cycle of the port write. Otherwise they produce no strobe.
- R8: A port write that targets number 17 (the pointer's own number) produces no strobe and does not load the pointer from the data. The pointer only advances as in R4.
- R9: On auto-increment, the pointer number wraps from 63 to 0.
- R10: When a direct load and a port write occur in the same cycle, the port write uses the old pointer number and the pointer takes the loaded value, with no increment.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_en | input | 1 | Makes registers 25 to 27 writable |
| ptr_wr_en | input | 1 | Direct load strobe for the pointer register |
| ptr_wr_data | input | 8 | Pointer value: bit 7 inhibit, bits 5..0 number |
| port_wr_en | input | 1 | Indirect port write strobe |
| port_wr_data | input | 8 | Byte to forward |
| reg_we | output | 1 | Control register write strobe |
| reg_num | output | 6 | Target control register number |
| reg_data | output | 8 | Data for the target register |

## Verification
Bursts with auto-increment enabled show that the pointer advances after each write. Bursts with the inhibit flag set show that it holds, and a loaded byte with bit 6 set shows that this bit is ignored. Bursts that start just below the edges of each writable range (23/24, 24 to 28 with `ext_en` low and then high, 31/32, 46/47, 62 to 1) check that dropped writes still move the pointer and that the number wraps. A write to the pointer's own number, carrying a byte that would redirect the pointer, is followed by another write to show that the pointer was not altered. A direct load issued in the same cycle as a port write shows which pointer value each one uses.

// File: rtl/ireg_pkg.sv
package ireg_pkg;
  localparam int DFLT_NUM_W  = 6;
  localparam int DFLT_DATA_W = 8;
  localparam int DFLT_SELF   = 17;
  localparam int DFLT_NRANGE = 2;
endpackage

// File: rtl/ireg_ptr.sv
module ireg_ptr #(
  parameter int NUM_W  = ireg_pkg::DFLT_NUM_W,
  parameter int DATA_W = ireg_pkg::DFLT_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [DATA_W-1:0] load_data,
  input  logic              step_en,
  output logic [NUM_W-1:0]  num,
  output logic              inh
);
  localparam int INH_BIT = DATA_W - 1;

  logic [NUM_W-1:0] num_q, num_d;
  logic             inh_q, inh_d;
  logic             upd_en;
  logic [DATA_W-2:NUM_W] unused_gap;

  assign unused_gap = load_data[DATA_W-2:NUM_W];

  // load has priority over the increment
  always_comb begin
    num_d  = num_q;
    inh_d  = inh_q;
    upd_en = 1'b0;
    if (load_en) begin
      num_d  = load_data[NUM_W-1:0];
      inh_d  = load_data[INH_BIT];
      upd_en = 1'b1;
    end else if (step_en && !inh_q) begin
      num_d  = num_q + 1'b1;
      upd_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      num_q <= '0;
      inh_q <= 1'b0;
    end else if (upd_en) begin
      num_q <= num_d;
      inh_q <= inh_d;
    end
  end

  assign num = num_q;
  assign inh = inh_q;
endmodule

// File: rtl/ireg_filter.sv
module ireg_filter #(
  parameter int NUM_W   = ireg_pkg::DFLT_NUM_W,
  parameter int NRANGE  = ireg_pkg::DFLT_NRANGE,
  parameter logic [NRANGE*NUM_W-1:0] RANGE_LO = {6'd32, 6'd0},
  parameter logic [NRANGE*NUM_W-1:0] RANGE_HI = {6'd46, 6'd23},
  parameter logic [NUM_W-1:0] EXT_LO   = 6'd25,
  parameter logic [NUM_W-1:0] EXT_HI   = 6'd27,
  parameter logic [NUM_W-1:0] SELF_NUM = 6'd17
) (
  input  logic [NUM_W-1:0] num,
  input  logic             ext_en,
  output logic             ok
);
  logic [NRANGE-1:0] hit;
  logic              ext_hit;

  // offset compare: (num - lo) <= (hi - lo) in NUM_W bits
  for (genvar g = 0; g < NRANGE; g++) begin : g_rng
    logic [NUM_W-1:0] lo, hi, off;
    assign lo     = RANGE_LO[g*NUM_W +: NUM_W];
    assign hi     = RANGE_HI[g*NUM_W +: NUM_W];
    assign off    = num - lo;
    assign hit[g] = off <= (hi - lo);
  end

  logic [NUM_W-1:0] ext_off;
  assign ext_off = num - EXT_LO;
  assign ext_hit = ext_en && (ext_off <= (EXT_HI - EXT_LO));

  assign ok = ((|hit) || ext_hit) && (num != SELF_NUM);
endmodule

// File: rtl/ireg_out.sv
module ireg_out #(
  parameter int NUM_W  = ireg_pkg::DFLT_NUM_W,
  parameter int DATA_W = ireg_pkg::DFLT_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [NUM_W-1:0]  num_in,
  input  logic [DATA_W-1:0] data_in,
  output logic              we,
  output logic [NUM_W-1:0]  num,
  output logic [DATA_W-1:0] data
);
  logic              we_d;
  logic [NUM_W-1:0]  num_d;
  logic [DATA_W-1:0] data_d;

  always_comb begin
    we_d   = fire;
    num_d  = num_in;
    data_d = data_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we <= 1'b0;
    end else begin
      we <= we_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      num  <= '0;
      data <= '0;
    end else if (fire) begin
      num  <= num_d;
      data <= data_d;
    end
  end
endmodule

// File: rtl/ireg_port.sv
module ireg_port #(
  parameter int NUM_W  = ireg_pkg::DFLT_NUM_W,
  parameter int DATA_W = ireg_pkg::DFLT_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_en,
  input  logic              ptr_wr_en,
  input  logic [DATA_W-1:0] ptr_wr_data,
  input  logic              port_wr_en,
  input  logic [DATA_W-1:0] port_wr_data,
  output logic              reg_we,
  output logic [NUM_W-1:0]  reg_num,
  output logic [DATA_W-1:0] reg_data
);
  localparam logic [NUM_W-1:0] SELF_NUM = NUM_W'(ireg_pkg::DFLT_SELF);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [NUM_W-1:0] ptr_num;
  logic             ptr_inh;
  logic             tgt_ok;
  logic             fire;

  ireg_ptr #(.NUM_W(NUM_W), .DATA_W(DATA_W)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .load_en   (ptr_wr_en),
    .load_data (ptr_wr_data),
    .step_en   (port_wr_en),
    .num       (ptr_num),
    .inh       (ptr_inh)
  );

  ireg_filter #(.NUM_W(NUM_W), .SELF_NUM(SELF_NUM)) u_flt (
    .num    (ptr_num),
    .ext_en (ext_en),
    .ok     (tgt_ok)
  );

  logic unused_inh;
  assign unused_inh = ptr_inh;
  assign fire       = port_wr_en && tgt_ok;

  ireg_out #(.NUM_W(NUM_W), .DATA_W(DATA_W)) u_out (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .fire    (fire),
    .num_in  (ptr_num),
    .data_in (port_wr_data),
    .we      (reg_we),
    .num     (reg_num),
    .data    (reg_data)
  );
endmodule

// File: rtl/ireg_port_chk.sv
module ireg_port_chk #(
  parameter int NUM_W  = 6,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ext_en,
  input logic              port_wr_en,
  input logic [DATA_W-1:0] port_wr_data,
  input logic              reg_we,
  input logic [NUM_W-1:0]  reg_num,
  input logic [DATA_W-1:0] reg_data
);
  logic in_base, in_ext;
  assign in_base = (reg_num <= NUM_W'(23)) ||
                   ((reg_num >= NUM_W'(32)) && (reg_num <= NUM_W'(46)));
  assign in_ext  = (reg_num >= NUM_W'(25)) && (reg_num <= NUM_W'(27));

  assert_strobe_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> $past(port_wr_en));
  assert_data_forward_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> (reg_data == $past(port_wr_data)));
  assert_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> (in_base || in_ext));
  assert_ext_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && in_ext) |-> $past(ext_en));
  assert_self_protect_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> (reg_num != NUM_W'(17)));
endmodule

bind ireg_port ireg_port_chk #(.NUM_W(NUM_W), .DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ext_en       (ext_en),
  .port_wr_en   (port_wr_en),
  .port_wr_data (port_wr_data),
  .reg_we       (reg_we),
  .reg_num      (reg_num),
  .reg_data     (reg_data)
);

// File: tb/ireg_port_test.sv
`timescale 1ns/1ps
module ireg_port_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ext_en, ptr_wr_en, port_wr_en;
  logic [7:0] ptr_wr_data, port_wr_data;
  logic       reg_we;
  logic [5:0] reg_num;
  logic [7:0] reg_data;

  always #5 clk = ~clk;

  ireg_port uut (
    .clk(clk), .rst_n(rst_n), .ext_en(ext_en),
    .ptr_wr_en(ptr_wr_en), .ptr_wr_data(ptr_wr_data),
    .port_wr_en(port_wr_en), .port_wr_data(port_wr_data),
    .reg_we(reg_we), .reg_num(reg_num), .reg_data(reg_data)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [13:0] exp_q[$];
  string       tag_q[$];
  logic [5:0]  m_num;
  logic        m_inh;
  bit          live = 1'b0;

  task automatic chk(input bit good, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!good) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit exp_ok(input int n, input bit ext);
    return ((n <= 23) || (n >= 32 && n <= 46) || (ext && n >= 25 && n <= 27))
           && (n != 17);
  endfunction

  task automatic ld(input logic [7:0] v);
    @(negedge clk);
    ptr_wr_en = 1'b1; ptr_wr_data = v;
    m_num = v[5:0]; m_inh = v[7];
    @(negedge clk);
    ptr_wr_en = 1'b0;
  endtask

  task automatic pw(input logic [7:0] d, input string tag,
                    input bit with_ld = 1'b0, input logic [7:0] lv = 8'h00);
    bit ok;
    @(negedge clk);
    port_wr_en = 1'b1; port_wr_data = d;
    ok = exp_ok(int'(m_num), ext_en);
    if (ok) begin
      exp_q.push_back({m_num, d});
      tag_q.push_back(tag);
    end
    if (with_ld) begin
      ptr_wr_en = 1'b1; ptr_wr_data = lv;
      m_num = lv[5:0]; m_inh = lv[7];
    end else if (!m_inh) begin
      m_num = m_num + 6'd1;
    end
    @(negedge clk);
    port_wr_en = 1'b0; ptr_wr_en = 1'b0;
    if (!ok) chk(reg_we == 1'b0, tag, "dropped write strobe", int'(reg_we), 0);
  endtask

  // monitor: compare every strobe against the scoreboard
  always @(negedge clk) begin
    if (live && reg_we) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2", "unexpected strobe reg", int'(reg_num), -1);
      end else begin
        logic [13:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(reg_num == e[13:8], t, "reg_num", int'(reg_num), int'(e[13:8]));
        chk(reg_data == e[7:0], t, "reg_data", int'(reg_data), int'(e[7:0]));
      end
    end
  end

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ext_en = 1'b0; ptr_wr_en = 1'b0; port_wr_en = 1'b0;
    ptr_wr_data = '0; port_wr_data = '0;
    m_num = '0; m_inh = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(reg_we == 1'b0, "R1", "reset strobe", int'(reg_we), 0);
    live = 1'b1;

    // R1/R4: auto-increment from reset pointer
    pw(8'hA1, "R1"); pw(8'hA2, "R4"); pw(8'hA3, "R4");
    // R5: inhibit set, register 5 repeatedly
    ld(8'h85);
    pw(8'h11, "R5"); pw(8'h12, "R5"); pw(8'h13, "R5");
    // R3: bit 6 ignored; R6/R7 range edges with ext low
    ld(8'h54);
    pw(8'h20, "R3"); pw(8'h21, "R6"); pw(8'h22, "R6"); pw(8'h23, "R6");
    pw(8'h24, "R6"); pw(8'h25, "R7");
    // R7: ext high
    ext_en = 1'b1;
    ld(8'd24);
    pw(8'h30, "R6"); pw(8'h31, "R7"); pw(8'h32, "R7"); pw(8'h33, "R7");
    pw(8'h34, "R6");
    ext_en = 1'b0;
    // R8: self number skipped, pointer advances
    ld(8'd15);
    pw(8'h40, "R8"); pw(8'h41, "R8"); pw(8'h42, "R8"); pw(8'h43, "R8");
    // R8: data aimed at the pointer must not reload it
    ld(8'h91);
    pw(8'h05, "R8"); pw(8'h06, "R8");
    // R6: upper range edges
    ld(8'd31);
    pw(8'h50, "R6"); pw(8'h51, "R6"); pw(8'h52, "R6");
    ld(8'd45);
    pw(8'h53, "R6"); pw(8'h54, "R6"); pw(8'h55, "R6");
    // R9: wrap 63 -> 0
    ld(8'd62);
    pw(8'h60, "R9"); pw(8'h61, "R9"); pw(8'h62, "R9"); pw(8'h63, "R9");
    // R10: simultaneous load and port write
    pw(8'h70, "R10", 1'b1, 8'd10);
    pw(8'h71, "R10");

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R2", "missing strobes", exp_q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule